// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a simple synchronous request port to an asynchronous 1M x 16 fast-page-mode DRAM. A request carries a 20-bit word address, a read/write flag, 16 bits of write data and two byte enables. The controller sends the upper ten address bits as the row and the lower ten as the column, one after the other, on a shared 10-bit address bus. It generates the row strobe, separate lower and upper column strobes, the write enable and the output enable. All timing values are given in nanoseconds and converted to whole clock cycles, rounded up.

After an access the row stays open. A later access to the same row needs only a column cycle, with no new row strobe. An access to another row closes the open row, waits out the precharge time and then opens the new row. Refresh is requested at a fixed cadence of one cycle per row interval. When a refresh is due, the controller closes the open row, precharges, and runs a column-before-row refresh cycle. It then leaves every row closed. The request port uses a valid/ready handshake. Read data comes back with a one-cycle valid pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row bus value is req_addr[19:10] and the column is req_addr[9:0]. The row is on dram_addr before dram_ras_n falls, and the column is on it before a column strobe falls.
- R2: Before each falling edge of dram_ras_n, dram_ras_n is high for at least RP_CYC cycles (2 by default). For an access, both column strobes are high when dram_ras_n falls.
- R3: An access to the row that is open does not cause a new falling edge of dram_ras_n.
- R4: For a write, req_be[0] strobes dram_lcas_n (bits 7:0) and req_be[1] strobes dram_ucas_n (bits 15:8). A byte whose enable is 0 keeps its earlier contents.
- R5: Each read gives rd_valid high for exactly one cycle. Each byte of rd_data whose enable is 0 reads as zero, and each enabled byte holds the stored value.
- R6: A refresh is requested every REF_CYC cycles (780 by default). The controller then lowers both column strobes at least one cycle before dram_ras_n falls. After a refresh no row is open, so the next access reopens its row.
- R7: req_ready is low while an access is in progress and while a refresh is pending or running. It is high when the controller is idle.
- R8: During and after reset, dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n and dram_oe_n are high, while dram_dq_oe and rd_valid are low.
- R9: For a write, dram_we_n is low at least one cycle before a column strobe falls. While write data is driven, dram_dq_oe is high and dram_oe_n is high.
- R10: A read holds dram_oe_n low while its column strobe is low. dram_dq_oe stays low during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in upper half |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, disabled bytes zero |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
The accesses are run against a behavioural memory model that latches the row and the column from the bus on the strobe edges. The sequence mixes same-row reads and writes, which must reuse the open row, with jumps to other rows, and then returns to an earlier row. This separates page hits from misses and shows whether the row and column halves were swapped. Writes with a single byte enabled, followed by reads with full and partial enables, show whether each column strobe reached the right byte lane. The partial reads also show whether a disabled lane is masked to zero. Idle stretches let refresh run on its own. They check the spacing between refreshes, the order of the column and row strobes, and that the next access after a refresh reopens its row.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_COLS, ST_CASL, ST_CASP,
    ST_RPRE, ST_RCAS, ST_RRAS, ST_RREC
  } fpm_state_e;

  function automatic int ns2cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col
);
  assign row = addr[ROW_W+COL_W-1:COL_W];
  assign col = addr[COL_W-1:0];
endmodule

// File: rtl/fpm_wait_timer.sv
module fpm_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_en = load || !done;
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int INTERVAL = 780,
  localparam int W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         wrap;
  logic         pend_d;

  always_comb begin
    wrap   = (cnt_q == W'(INTERVAL - 1));
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    pend_d = wrap | (pending & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ROW_W         = 10,
  parameter int COL_W         = 10,
  parameter int DATA_W        = 16,
  parameter int T_RP_NS       = 30,
  parameter int T_RCD_NS      = 20,
  parameter int T_RAC_NS      = 50,
  parameter int T_CAC_NS      = 13,
  parameter int T_AA_NS       = 25,
  parameter int T_CP_NS       = 10,
  parameter int T_RAS_NS      = 50,
  parameter int T_REF_NS      = 15600,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int BE_W    = DATA_W / 8,
  localparam int BUS_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int RP_CYC  = max2(ns2cyc(T_RP_NS, CLK_PERIOD_NS), 1),
  localparam int CAS_CYC = max2(max2(ns2cyc(T_CAC_NS, CLK_PERIOD_NS),
                                     ns2cyc(T_AA_NS, CLK_PERIOD_NS) - 1), 1),
  localparam int RCD_CYC = max2(max2(ns2cyc(T_RCD_NS, CLK_PERIOD_NS),
                                     ns2cyc(T_RAC_NS, CLK_PERIOD_NS) - 1 - CAS_CYC), 1),
  localparam int CP_CYC  = max2(ns2cyc(T_CP_NS, CLK_PERIOD_NS), 1),
  localparam int RAS_CYC = max2(ns2cyc(T_RAS_NS, CLK_PERIOD_NS), 1),
  localparam int REF_CYC = max2(T_REF_NS / CLK_PERIOD_NS, 2),
  localparam int TW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [BUS_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_lcas_n,
  output logic              dram_ucas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  fpm_state_e state_q, state_d;
  logic             row_open_q, row_open_d;
  logic [ROW_W-1:0] open_row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [BE_W-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;

  logic [ROW_W-1:0] in_row;
  logic [COL_W-1:0] in_col;
  logic             accept;
  logic             ref_pend, ref_ack;
  logic             wait_done, wait_load;
  logic [TW-1:0]    wait_val;

  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_wr;
  logic [BE_W-1:0]  cur_be;
  logic [DATA_W-1:0] cur_wdata;

  logic             ras_n_d, lcas_n_d, ucas_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic [BUS_W-1:0] addr_d;
  logic             addr_en;
  logic             capture;
  logic [DATA_W-1:0] rd_mask;

  fpm_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .row(in_row), .col(in_col)
  );

  fpm_refresh_timer #(.INTERVAL(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_core_n), .ack(ref_ack), .pending(ref_pend)
  );

  fpm_wait_timer #(.W(TW)) u_wait (
    .clk(clk), .rst_n(rst_core_n), .load(wait_load),
    .load_val(wait_val), .done(wait_done)
  );

  assign req_ready = (state_q == ST_IDLE) && !ref_pend;

  // next state
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    ref_ack = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          state_d = ST_RPRE;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          accept  = 1'b1;
          state_d = (row_open_q && in_row == open_row_q) ? ST_COLS : ST_PRE;
        end
      end
      ST_PRE:  if (wait_done) state_d = ST_ACT;
      ST_ACT:  if (wait_done) state_d = ST_COLS;
      ST_COLS: if (wait_done) state_d = ST_CASL;
      ST_CASL: if (wait_done) state_d = ST_CASP;
      ST_CASP: if (wait_done) state_d = ST_IDLE;
      ST_RPRE: if (wait_done) state_d = ST_RCAS;
      ST_RCAS: if (wait_done) state_d = ST_RRAS;
      ST_RRAS: if (wait_done) state_d = ST_RREC;
      ST_RREC: if (wait_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // dwell time of the state being entered
  always_comb begin
    wait_load = (state_d != state_q);
    unique case (state_d)
      ST_PRE, ST_RPRE, ST_RREC: wait_val = TW'(RP_CYC - 1);
      ST_ACT:                   wait_val = TW'(RCD_CYC - 1);
      ST_CASL:                  wait_val = TW'(CAS_CYC - 1);
      ST_CASP:                  wait_val = TW'(CP_CYC - 1);
      ST_RRAS:                  wait_val = TW'(RAS_CYC - 1);
      default:                  wait_val = '0;
    endcase
  end

  // request fields seen by the strobe decode
  always_comb begin
    cur_row   = accept ? in_row    : open_row_q;
    cur_col   = accept ? in_col    : col_q;
    cur_wr    = accept ? req_write : wr_q;
    cur_be    = accept ? req_be    : be_q;
    cur_wdata = accept ? req_wdata : wdata_q;
  end

  always_comb begin
    row_open_d = row_open_q;
    if (state_d == ST_ACT)                              row_open_d = 1'b1;
    else if (state_d == ST_PRE || state_d == ST_RPRE)   row_open_d = 1'b0;

    ras_n_d  = !((state_d inside {ST_ACT, ST_COLS, ST_CASL, ST_CASP, ST_RRAS}) ||
                 (state_d == ST_IDLE && row_open_d));
    lcas_n_d = !((state_d == ST_CASL && cur_be[0]) || (state_d inside {ST_RCAS, ST_RRAS}));
    ucas_n_d = !((state_d == ST_CASL && cur_be[BE_W-1]) || (state_d inside {ST_RCAS, ST_RRAS}));
    we_n_d   = !((state_d inside {ST_COLS, ST_CASL}) && cur_wr);
    oe_n_d   = !(state_d == ST_CASL && !cur_wr);
    dq_oe_d  = (state_d inside {ST_COLS, ST_CASL}) && cur_wr;

    addr_en = 1'b1;
    if (state_d inside {ST_PRE, ST_ACT})        addr_d = BUS_W'(cur_row);
    else if (state_d inside {ST_COLS, ST_CASL}) addr_d = BUS_W'(cur_col);
    else begin
      addr_d  = dram_addr;
      addr_en = 1'b0;
    end

    capture = (state_q == ST_CASL) && wait_done && !wr_q;
    for (int b = 0; b < BE_W; b++) rd_mask[b*8 +: 8] = {8{be_q[b]}};
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q     <= ST_IDLE;
      row_open_q  <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_lcas_n <= 1'b1;
      dram_ucas_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      open_row_q  <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      be_q        <= '0;
      wdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      row_open_q  <= row_open_d;
      dram_ras_n  <= ras_n_d;
      dram_lcas_n <= lcas_n_d;
      dram_ucas_n <= ucas_n_d;
      dram_we_n   <= we_n_d;
      dram_oe_n   <= oe_n_d;
      dram_dq_oe  <= dq_oe_d;
      rd_valid    <= capture;
      if (addr_en) dram_addr   <= addr_d;
      if (dq_oe_d) dram_dq_out <= cur_wdata;
      if (capture) rd_data     <= dram_dq_in & rd_mask;
      if (accept) begin
        open_row_q <= in_row;
        col_q      <= in_col;
        wr_q       <= req_write;
        be_q       <= req_be;
        wdata_q    <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int RP_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_lcas_n,
  input logic dram_ucas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  logic [7:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        high_cnt <= '0;
    else if (!dram_ras_n)              high_cnt <= '0;
    else if (high_cnt != 8'hFF)        high_cnt <= high_cnt + 8'd1;
  end

  // R2: precharge time honoured before every row strobe edge
  assert_precharge_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (high_cnt >= 8'(RP_CYC)));

  // R2 / R6: column strobes move together at a row strobe edge
  assert_ras_fall_cas_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (dram_lcas_n == dram_ucas_n));

  // R5: read strobe lasts one cycle
  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7: no column activity while accepting requests
  assert_idle_no_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_lcas_n && dram_ucas_n));

  // R9: never drive data while the memory may drive
  assert_no_bus_fight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);

  // R9: write enable does not move while a column strobe stays low
  assert_we_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_lcas_n && $past(!dram_lcas_n) && !dram_ras_n) |-> $stable(dram_we_n));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.RP_CYC(RP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  localparam int EXP_RP  = 2;    // ceil(30/20)
  localparam int EXP_RAS = 3;    // ceil(50/20)
  localparam int EXP_REF = 780;  // 15600/20

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [9:0]  dram_addr;
  logic dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = 16'hEEEE;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fpm_dram_ctrl u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory, evaluated on the falling clock edge
  logic [7:0] mem_lo [int];
  logic [7:0] mem_hi [int];
  logic [9:0] m_row, m_col;
  logic p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
  int hi_cnt = 0, lo_cnt = 0, cyc = 0;
  int row_opens = 0, refreshes = 0, last_ref_cyc = 0, ref_gap = 0;

  always @(negedge clk) begin
    int key;
    cyc++;
    if (rst_n) begin
      if (!dram_ras_n && p_ras) begin
        if (!dram_lcas_n && !dram_ucas_n) begin
          chk(!p_l && !p_u, "R6 cas before ras", p_l, 0);
          chk(!req_ready, "R7 ready during refresh", req_ready, 0);
          refreshes++;
          ref_gap = cyc - last_ref_cyc;
          last_ref_cyc = cyc;
        end else begin
          chk(dram_lcas_n && dram_ucas_n, "R2 cas high at row open", dram_lcas_n, 1);
          m_row = dram_addr;
          row_opens++;
        end
        chk(hi_cnt >= EXP_RP, "R2 precharge width", hi_cnt, EXP_RP);
      end
      if (dram_ras_n && !p_ras) chk(lo_cnt >= EXP_RAS, "R2 ras low width", lo_cnt, EXP_RAS);
      if (!dram_ras_n && !p_ras && ((!dram_lcas_n && p_l) || (!dram_ucas_n && p_u))) begin
        m_col = dram_addr;
        key = int'({m_row, m_col});
        if (!dram_we_n) begin
          chk(!p_we, "R9 we before cas", p_we, 0);
          chk(dram_dq_oe && dram_oe_n, "R9 data drive", dram_dq_oe, 1);
          if (!dram_lcas_n) mem_lo[key] = dram_dq_out[7:0];
          if (!dram_ucas_n) mem_hi[key] = dram_dq_out[15:8];
        end else begin
          chk(!dram_oe_n && !dram_dq_oe, "R10 read enables", dram_oe_n, 0);
        end
      end
      key = int'({m_row, m_col});
      dram_dq_in[7:0]  = (!dram_lcas_n && !dram_oe_n) ? (mem_lo.exists(key) ? mem_lo[key] : 8'h00) : 8'hEE;
      dram_dq_in[15:8] = (!dram_ucas_n && !dram_oe_n) ? (mem_hi.exists(key) ? mem_hi[key] : 8'h00) : 8'hEE;
      if (dram_ras_n) begin hi_cnt++; lo_cnt = 0; end
      else begin lo_cnt++; hi_cnt = 0; end
    end
    p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
  end

  task automatic run_op(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be, input logic [15:0] exp, input bit miss);
    int opens0;
    int n;
    opens0 = row_opens;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7 ready low while busy", req_ready, 0);
    if (!wr) begin
      n = 0;
      while (!rd_valid && n < 40) begin @(negedge clk); n++; end
      chk(rd_valid, "R5 read strobe", rd_valid, 1);
      chk(rd_data == exp, "R4 R5 read data", rd_data, exp);
      @(negedge clk);
      chk(!rd_valid, "R5 one-cycle strobe", rd_valid, 0);
    end
    n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    chk((row_opens - opens0) == int'(miss), miss ? "R1 R2 row reopen" : "R3 page hit", row_opens - opens0, miss);
  endtask

  // {write, addr, wdata, be, expected read, row miss}
  localparam int NV = 11;
  localparam logic [55:0] VEC [NV] = '{
    {1'b1, 20'h00005, 16'hA5A5, 2'b11, 16'h0000, 1'b1},
    {1'b0, 20'h00005, 16'h0000, 2'b11, 16'hA5A5, 1'b0},
    {1'b1, 20'h00006, 16'h1234, 2'b01, 16'h0000, 1'b0},
    {1'b1, 20'h00006, 16'hBEEF, 2'b10, 16'h0000, 1'b0},
    {1'b0, 20'h00006, 16'h0000, 2'b11, 16'hBE34, 1'b0},
    {1'b0, 20'h00006, 16'h0000, 2'b01, 16'h0034, 1'b0},
    {1'b1, 20'h40006, 16'h7777, 2'b11, 16'h0000, 1'b1},
    {1'b0, 20'h00006, 16'h0000, 2'b10, 16'hBE00, 1'b1},
    {1'b0, 20'h40006, 16'h0000, 2'b11, 16'h7777, 1'b1},
    {1'b1, 20'hFFFFF, 16'hC3C3, 2'b11, 16'h0000, 1'b1},
    {1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'hC3C3, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R8 strobes high in reset", dram_ras_n, 1);
    chk(dram_we_n && dram_oe_n, "R8 we/oe high in reset", dram_we_n, 1);
    chk(!dram_dq_oe && !rd_valid, "R8 no drive in reset", dram_dq_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R7 ready when idle", req_ready, 1);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R8 strobes high after reset", dram_ras_n, 1);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      run_op(v[55], v[54:35], v[34:19], v[18:17], v[16:1], v[0]);
    end

    // R6: refresh cadence while idle, then the open row is gone
    begin
      int r0;
      int n;
      r0 = refreshes;
      n = 0;
      while (refreshes < r0 + 2 && n < 3000) begin @(negedge clk); n++; end
      chk(refreshes >= r0 + 2, "R6 refresh issued", refreshes - r0, 2);
      chk(ref_gap == EXP_REF, "R6 refresh interval", ref_gap, EXP_REF);
      repeat (5) @(negedge clk);
      chk(req_ready && dram_ras_n, "R6 row closed after refresh", dram_ras_n, 1);
    end
    run_op(1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'hC3C3, 1'b1);
    run_op(1'b0, 20'h40006, 16'h0000, 2'b01, 16'h0077, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule